// File: doc/BRIEF.md
# Converter Serial Port with Streaming Result Readout

This block is the device side of a three-wire serial link for a delta-sigma converter. A conversion engine hands it a 24-bit result, a one-cycle valid strobe and a channel index. The host drives a serial clock, a select line and a command input, and reads one combined data/ready output. Commands arrive as bytes on the command input. A mode register holds an option that appends a status byte to each result.

Once the host has sent the streaming command, the port needs no further command to deliver results. Each new conversion pulls the output low to show that a result is waiting. The host then clocks the word out. When the word has been read, the line returns high. While streaming, the port keeps assembling bytes from the command input. It leaves streaming when it sees the exit byte while a result is pending. A run of forty ones on the command input resets the whole interface. All host inputs are synchronised to the system clock and edge-detected. The block reacts to a serial clock edge three system clocks after that edge.

Top module: `adc_cread_port`

## Requirements
- R1: After reset, the output enable is low, the data line reads 1, streaming mode is off and the mode register is zero.
- R2: While select is high, the output enable is low, and any command bits received so far are discarded. A byte that was only partly shifted in therefore never counts toward the next byte after select returns low.
- R3: The command byte 0x5C, sent MSB first with each bit sampled on a rising serial clock edge, enters streaming mode. In streaming mode, each conversion strobe drives the data line low (ready) on the next system clock.
- R4: A pending result is shifted out MSB first. Each falling serial clock edge presents the next bit, starting with the MSB on the first falling edge. The frame is the 24-bit conversion word.
- R5: After the last bit of the frame has been sampled on a rising edge, the data line returns high and stays high under further serial clocking until the next conversion. A result can be read only once.
- R6: When a conversion arrives before the pending frame has been fully read, the partial read is abandoned. The line goes low again, and the new result is what is shifted out.
- R7: The byte 0x08 followed by a data byte writes the mode register. When bit 4 of the mode register is set, each frame is 32 bits: the conversion word followed by a status byte whose bits [3:0] carry the channel index and whose bits [7:4] are zero.
- R8: In streaming mode, the byte 0x58 leaves streaming mode only if a result is pending when the byte completes. On exit, the line goes high at once and later conversions leave it high. Sent with no result pending, 0x58 is ignored.
- R9: Forty consecutive ones sampled on the command input, with select low, reset the interface: streaming mode ends and the mode register clears. Thirty-nine ones followed by a zero have no effect.
- R10: Conversion strobes outside streaming mode leave the data line high.
- R11: Outside streaming mode, command bytes other than 0x5C and 0x08 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Host serial clock, idles high |
| cs_n | input | 1 | Host select, active low |
| din | input | 1 | Host command/data input |
| conv_data | input | 24 | Conversion result from the engine |
| conv_valid | input | 1 | One-cycle strobe: conv_data and conv_chan are new |
| conv_chan | input | 4 | Channel index of the result |
| dout | output | 1 | Combined data and ready line, low means a result is waiting |
| dout_oe | output | 1 | Output enable for dout; low models high impedance |

## Verification
A mode state that is stuck or was entered wrongly shows within two system clocks of the next conversion strobe: the ready level on the data line is wrong. A serial bit counter that is off by one does not show immediately. It shows on the next frame as a shifted word or a ready level that stays low. Command byte misalignment shows only when a command is later ignored. The ones counter shows only at the 39/40 boundary, so both sides of that boundary are driven. The overwrite path is exercised in mid-frame, where a stale shift state would corrupt the leading bits.

// File: rtl/adc_sp_pkg.sv
package adc_sp_pkg;

    localparam logic [7:0] CMD_STREAM_ON  = 8'h5C;
    localparam logic [7:0] CMD_STREAM_OFF = 8'h58;
    localparam logic [7:0] CMD_MODE_WR    = 8'h08;
    localparam int         MODE_STAT_BIT  = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MODE_DATA,
        ST_STREAM
    } port_state_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic sel;
    } host_evt_t;

    function automatic logic [7:0] status_byte(input logic [7:0] chan_ext);
        return {4'b0000, chan_ext[3:0]};
    endfunction

endpackage

// File: rtl/adc_sp_sync.sv
module adc_sp_sync
    import adc_sp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      sclk,
    input  logic      cs_n,
    input  logic      din,
    output host_evt_t evt,
    output logic      din_s
);
    localparam logic [2:0] IDLE_VAL = 3'b110;

    logic [SYNC_STAGES-1:0][2:0] pipe;
    logic                        sclk_q;
    logic [2:0]                  last;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    pipe[g] <= IDLE_VAL;
                end else if (g == 0) begin
                    pipe[g] <= {sclk, cs_n, din};
                end else begin
                    pipe[g] <= pipe[g-1];
                end
            end
        end
    endgenerate

    assign last = pipe[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) sclk_q <= 1'b1;
        else     sclk_q <= last[2];
    end

    assign evt.rise = last[2] & ~sclk_q;
    assign evt.fall = ~last[2] & sclk_q;
    assign evt.sel  = ~last[1];
    assign din_s    = last[0];

endmodule

// File: rtl/adc_sp_rx.sv
module adc_sp_rx
    import adc_sp_pkg::*;
#(
    parameter int ONES_LIMIT = 40
) (
    input  logic       clk,
    input  logic       rst,
    input  host_evt_t  evt,
    input  logic       din_s,
    output logic       byte_done,
    output logic [7:0] byte_val,
    output logic       ones_rst
);
    localparam int OW = $clog2(ONES_LIMIT + 1);

    logic [2:0]    bit_cnt;
    logic [6:0]    shreg;
    logic [OW-1:0] ones;
    logic          take;

    assign take      = evt.sel & evt.rise;
    assign ones_rst  = take & din_s & (ones == OW'(ONES_LIMIT - 1));
    assign byte_done = take & (bit_cnt == 3'd7);
    assign byte_val  = {shreg, din_s};

    always_ff @(posedge clk) begin
        if (rst || !evt.sel || ones_rst) begin
            bit_cnt <= '0;
            shreg   <= '0;
            ones    <= '0;
        end else if (take) begin
            bit_cnt <= bit_cnt + 3'd1;
            shreg   <= {shreg[5:0], din_s};
            ones    <= din_s ? ones + OW'(1) : '0;
        end
    end

endmodule

// File: rtl/adc_sp_tx.sv
module adc_sp_tx
    import adc_sp_pkg::*;
#(
    parameter int FRAME_W = 32,
    parameter int LEN_W   = $clog2(FRAME_W + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               load,
    input  logic [FRAME_W-1:0] load_frame,
    input  logic [LEN_W-1:0]   load_len,
    input  host_evt_t          evt,
    output logic               dout_bit,
    output logic               pending
);
    logic [FRAME_W-1:0] sreg;
    logic [LEN_W-1:0]   len;
    logic [LEN_W-1:0]   cnt;
    logic               started;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            sreg    <= '0;
            len     <= '0;
            cnt     <= '0;
            started <= 1'b0;
            pending <= 1'b0;
        end else if (load) begin
            sreg    <= load_frame;
            len     <= load_len;
            cnt     <= '0;
            started <= 1'b0;
            pending <= 1'b1;
        end else if (!evt.sel) begin
            cnt     <= '0;
            started <= 1'b0;
        end else if (evt.fall && pending && cnt < len) begin
            if (started) sreg <= {sreg[FRAME_W-2:0], 1'b0};
            started <= 1'b1;
            cnt     <= cnt + LEN_W'(1);
        end else if (evt.rise && pending && started && cnt == len) begin
            pending <= 1'b0;
            started <= 1'b0;
            cnt     <= '0;
        end
    end

    assign dout_bit = !pending ? 1'b1 : (started ? sreg[FRAME_W-1] : 1'b0);

endmodule

// File: rtl/adc_cread_port.sv
module adc_cread_port
    import adc_sp_pkg::*;
#(
    parameter int RES_W       = 24,
    parameter int CH_W        = 4,
    parameter int ONES_LIMIT  = 40,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sclk,
    input  logic             cs_n,
    input  logic             din,
    input  logic [RES_W-1:0] conv_data,
    input  logic             conv_valid,
    input  logic [CH_W-1:0]  conv_chan,
    output logic             dout,
    output logic             dout_oe
);
    localparam int FRAME_W = RES_W + 8;
    localparam int LEN_W   = $clog2(FRAME_W + 1);

    host_evt_t          evt;
    logic               din_s;
    logic               byte_done;
    logic [7:0]         byte_val;
    logic               ones_rst;
    logic               tx_pending;
    logic               tx_bit;
    logic               exit_cmd;
    logic               tx_load;
    logic               tx_clear;
    logic [FRAME_W-1:0] frame;
    logic [LEN_W-1:0]   frame_len;
    logic [7:0]         stat;
    port_state_e        state;
    logic [7:0]         mode_reg;

    adc_sp_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .din(din),
        .evt(evt), .din_s(din_s)
    );

    adc_sp_rx #(.ONES_LIMIT(ONES_LIMIT)) u_rx (
        .clk(clk), .rst(rst), .evt(evt), .din_s(din_s),
        .byte_done(byte_done), .byte_val(byte_val), .ones_rst(ones_rst)
    );

    assign exit_cmd = (state == ST_STREAM) && byte_done &&
                      (byte_val == CMD_STREAM_OFF) && tx_pending;

    always_ff @(posedge clk) begin
        if (rst || ones_rst) begin
            state    <= ST_IDLE;
            mode_reg <= '0;
        end else if (byte_done) begin
            case (state)
                ST_IDLE: begin
                    if (byte_val == CMD_STREAM_ON)    state <= ST_STREAM;
                    else if (byte_val == CMD_MODE_WR) state <= ST_MODE_DATA;
                end
                ST_MODE_DATA: begin
                    mode_reg <= byte_val;
                    state    <= ST_IDLE;
                end
                ST_STREAM: begin
                    if (exit_cmd) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign stat      = status_byte(8'(conv_chan));
    assign frame     = mode_reg[MODE_STAT_BIT] ? {conv_data, stat} : {conv_data, 8'h00};
    assign frame_len = mode_reg[MODE_STAT_BIT] ? LEN_W'(FRAME_W) : LEN_W'(RES_W);
    assign tx_load   = conv_valid && (state == ST_STREAM);
    assign tx_clear  = ones_rst || exit_cmd;

    adc_sp_tx #(.FRAME_W(FRAME_W), .LEN_W(LEN_W)) u_tx (
        .clk(clk), .rst(rst), .clear(tx_clear), .load(tx_load),
        .load_frame(frame), .load_len(frame_len), .evt(evt),
        .dout_bit(tx_bit), .pending(tx_pending)
    );

    assign dout    = tx_bit;
    assign dout_oe = evt.sel;

endmodule

// File: rtl/adc_cread_chk.sv
module adc_cread_chk
    import adc_sp_pkg::*;
#(
    parameter int ONES_LIMIT = 40
) (
    input logic        clk,
    input logic        rst,
    input port_state_e state,
    input logic [7:0]  mode_reg,
    input logic        dout,
    input logic        conv_valid,
    input logic        byte_done,
    input logic [7:0]  byte_val,
    input logic        ones_rst,
    input logic        tx_pending
);
    // R10
    idle_line_high_chk: assert property (@(posedge clk) disable iff (rst)
        (state != ST_STREAM) |-> dout);

    // R3
    ready_low_chk: assert property (@(posedge clk) disable iff (rst)
        (conv_valid && state == ST_STREAM && !ones_rst && !byte_done) |=> !dout);

    // R9
    ones_reset_chk: assert property (@(posedge clk) disable iff (rst)
        ones_rst |=> (state == ST_IDLE && mode_reg == 8'h00));

    // R8
    exit_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STREAM && byte_done && byte_val == CMD_STREAM_OFF &&
         tx_pending && !ones_rst) |=> (state == ST_IDLE && dout));

    // R8
    no_pending_stay_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STREAM && byte_done && byte_val == CMD_STREAM_OFF &&
         !tx_pending && !ones_rst) |=> (state == ST_STREAM));
endmodule

bind adc_cread_port adc_cread_chk #(.ONES_LIMIT(ONES_LIMIT)) u_chk (
    .clk(clk), .rst(rst), .state(state), .mode_reg(mode_reg), .dout(dout),
    .conv_valid(conv_valid), .byte_done(byte_done), .byte_val(byte_val),
    .ones_rst(ones_rst), .tx_pending(tx_pending)
);

// File: tb/adc_cread_port_tb.sv
module adc_cread_port_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk = 1'b1;
    logic        cs_n = 1'b1;
    logic        din = 1'b0;
    logic [23:0] conv_data = '0;
    logic        conv_valid = 1'b0;
    logic [3:0]  conv_chan = '0;
    logic        dout;
    logic        dout_oe;

    int checks = 0;
    int errors = 0;
    bit model_stream = 1'b0;
    bit model_stat = 1'b0;

    typedef struct {
        logic [31:0] frame;
        int          len;
    } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    adc_cread_port u_dut (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .din(din),
        .conv_data(conv_data), .conv_valid(conv_valid), .conv_chan(conv_chan),
        .dout(dout), .dout_oe(dout_oe)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic half_period();
        repeat (4) @(negedge clk);
    endtask

    task automatic xfer(input logic [31:0] dword, input int n, output logic [31:0] got);
        got = '0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sclk = 1'b0;
            din  = dword[31-i];
            half_period();
            got  = {got[30:0], dout};
            sclk = 1'b1;
            half_period();
        end
        din = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        logic [31:0] g;
        xfer({b, 24'h0}, 8, g);
    endtask

    // driver: pulses a conversion and pushes the expected frame
    task automatic convert(input logic [23:0] d, input logic [3:0] ch);
        exp_t e;
        @(negedge clk);
        conv_data  = d;
        conv_chan  = ch;
        conv_valid = 1'b1;
        @(negedge clk);
        conv_valid = 1'b0;
        if (model_stream) begin
            e.frame = model_stat ? {d, 4'h0, ch} : {d, 8'h00};
            e.len   = model_stat ? 32 : 24;
            exp_q.delete();
            exp_q.push_back(e);
        end
        repeat (2) @(negedge clk);
    endtask

    // monitor: clocks a frame out and compares with the queue head
    task automatic read_frame(input string req);
        exp_t        e;
        logic [31:0] got;
        if (exp_q.size() == 0) begin
            check(1'b0, req, "no expected frame", 32'h0, 32'h0);
            return;
        end
        e = exp_q.pop_front();
        xfer(32'h0, e.len, got);
        if (e.len == 24) check(got[23:0] == e.frame[31:8], req, "frame24",
                               {8'h0, got[23:0]}, {8'h0, e.frame[31:8]});
        else             check(got == e.frame, req, "frame32", got, e.frame);
    endtask

    initial begin
        logic [31:0] g;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        // R1 reset state
        check(dout_oe == 1'b0, "R1", "oe after reset", {31'h0, dout_oe}, 32'h0);
        check(dout == 1'b1, "R1", "dout after reset", {31'h0, dout}, 32'h1);

        cs_n = 1'b0;
        half_period();
        check(dout_oe == 1'b1, "R2", "oe when selected", {31'h0, dout_oe}, 32'h1);

        // R10 conversion outside streaming mode
        convert(24'h111111, 4'd1);
        check(dout == 1'b1, "R10", "no ready outside stream", {31'h0, dout}, 32'h1);

        // R11 unknown command ignored
        send_byte(8'h33);
        convert(24'h222222, 4'd2);
        check(dout == 1'b1, "R11", "unknown cmd ignored", {31'h0, dout}, 32'h1);

        // R2 partial bits dropped by deselect, then R3 entry
        xfer(32'hF000_0000, 4, g);
        @(negedge clk); cs_n = 1'b1;
        half_period();
        check(dout_oe == 1'b0, "R2", "oe when deselected", {31'h0, dout_oe}, 32'h0);
        cs_n = 1'b0;
        half_period();
        send_byte(8'h5C);
        model_stream = 1'b1;
        convert(24'hA5C3F1, 4'd2);
        check(dout == 1'b0, "R3", "ready low after conversion", {31'h0, dout}, 32'h0);

        read_frame("R4");
        check(dout == 1'b1, "R5", "line high after read", {31'h0, dout}, 32'h1);
        xfer(32'h0, 8, g);
        check(g[7:0] == 8'hFF, "R5", "read only once", g, 32'hFF);

        // R6 overwrite of a partially read result
        convert(24'h123456, 4'd1);
        xfer(32'h0, 8, g);
        check(g[7:0] == 8'h12, "R6", "partial leading byte", g, 32'h12);
        convert(24'hFEDCBA, 4'd3);
        check(dout == 1'b0, "R6", "ready again after overwrite", {31'h0, dout}, 32'h0);
        read_frame("R6");

        // R8 exit byte with no result pending is ignored
        send_byte(8'h58);
        convert(24'h0F0F0F, 4'd0);
        check(dout == 1'b0, "R8", "stay streaming without pending", {31'h0, dout}, 32'h0);
        read_frame("R8");

        // R8 exit while a result is pending
        convert(24'h777777, 4'd0);
        xfer({8'h58, 24'h0}, 8, g);
        model_stream = 1'b0;
        exp_q.delete();
        repeat (2) @(negedge clk);
        check(dout == 1'b1, "R8", "line high after exit", {31'h0, dout}, 32'h1);
        convert(24'h888888, 4'd0);
        check(dout == 1'b1, "R8", "no ready after exit", {31'h0, dout}, 32'h1);

        // R7 status append
        send_byte(8'h08);
        send_byte(8'h10);
        model_stat = 1'b1;
        send_byte(8'h5C);
        model_stream = 1'b1;
        convert(24'hC0FFEE, 4'd5);
        read_frame("R7");
        convert(24'h00AA55, 4'd12);
        read_frame("R7");

        // R9 thirty-nine ones then zero: no reset
        xfer(32'hFFFF_FFFF, 32, g);
        xfer(32'hFE00_0000, 8, g);
        convert(24'h13579B, 4'd9);
        check(dout == 1'b0, "R9", "39 ones no reset", {31'h0, dout}, 32'h0);
        read_frame("R9");

        // R9 forty ones: reset
        xfer(32'hFFFF_FFFF, 32, g);
        xfer(32'hFF00_0000, 8, g);
        model_stream = 1'b0;
        model_stat = 1'b0;
        exp_q.delete();
        convert(24'h246802, 4'd4);
        check(dout == 1'b1, "R9", "40 ones left streaming", {31'h0, dout}, 32'h1);
        send_byte(8'h5C);
        model_stream = 1'b1;
        convert(24'h314159, 4'd7);
        read_frame("R9");

        @(negedge clk); cs_n = 1'b1;
        half_period();
        check(dout_oe == 1'b0, "R2", "oe low at end", {31'h0, dout_oe}, 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule